// File: doc/BRIEF.md
# Tick-Driven Duty-Cycle Waveform Generator

This block turns a strobe from an upstream rate generator into a pulse-width modulated level. A counter advances once per strobe and runs from zero up to a programmed span value, so that one output cycle lasts span+1 strobes. The output is high while the counter is below a programmed duty count. Each output cycle is therefore high for duty strobes out of span+1, which gives a ratio of duty/(span+1).

Both counts are 8 bits wide. Raising the duty count above the span gives a steady high level. For example, duty 0xFF with span 0xFE gives 100% duty. A duty count of zero gives a steady low level. The counts are sampled into shadow registers only at the end of a cycle, so a change never produces a cut-short or stretched cycle. When the enable is low, the counter is held at zero and the output is low. While the block is disabled, the shadows follow the inputs, so the first cycle after enabling uses the values present at that time.

The waveform rate depends only on the strobe rate. For example, a strobe at half of a 27 MHz reference with span 1 gives cycles of about 148 ns. The slowest strobe, one 65536th of that reference, with span 0xFF gives cycles of roughly 622 ms.

Top module: `tick_pwm`

## Requirements
- R1: During and after reset the output is low, and the first cycle after enabling starts at count zero.
- R2: One output cycle spans span_i+1 strobes. The counter wraps from the span value back to zero.
- R3: The counter moves only on clock edges where tick is high. Clock edges without a strobe leave the output unchanged.
- R4: With duty_i not above span_i, the output is high for the first duty_i strobes of every cycle and low for the rest.
- R5: A duty_i greater than span_i (for example 0xFF with span 0xFE) gives a constant high output.
- R6: duty_i equal to zero gives a constant low output.
- R7: New duty_i and span_i values take effect only from the next wrap. The cycle in progress completes with the old values.
- R8: With en low, the counter is held at zero and the output is low. Strobes are ignored. The shadows track the inputs.
- R9: span_i equal to zero gives one-strobe cycles, and the output is steadily high when duty_i is at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears the counter and forces the output low |
| tick | input | 1 | One-cycle strobe from the upstream rate generator |
| duty_i | input | 8 | High-time count in strobes |
| span_i | input | 8 | Cycle length minus one, in strobes |
| pwm_o | output | 1 | Waveform level |

## Verification
The assertions check these properties on every cycle:
- The counter never exceeds the active span.
- The counter wraps to zero at the end strobe and holds when there is no strobe.
- The counter is cleared and the output is low while disabled.
- The shadows change only on a load.
- The output is steadily high or low at the duty extremes.

Some behaviour can only be shown by the bench's scenarios, because it needs a whole sequence of strobes to observe:
- The exact high/low pattern across several cycles.
- A value change taking effect exactly at the wrap and not before.
- The restart at count zero after the enable is toggled.

// File: rtl/tick_pwm_pkg.sv
package tick_pwm_pkg;

    parameter int unsigned PWM_W = 8;

    typedef logic [PWM_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t duty;
        cnt_t span;
    } pwm_cfg_t;

    typedef enum logic [1:0] {
        ACT_CLEAR,
        ACT_HOLD,
        ACT_STEP,
        ACT_WRAP
    } cnt_act_e;

    function automatic cnt_act_e pick_act(input logic en, input logic tick,
                                          input logic at_end);
        if (!en)
            return ACT_CLEAR;
        else if (!tick)
            return ACT_HOLD;
        else if (at_end)
            return ACT_WRAP;
        else
            return ACT_STEP;
    endfunction

    function automatic logic level_f(input logic running, input cnt_t cnt,
                                     input cnt_t duty);
        return running && (cnt < duty);
    endfunction

endpackage

// File: rtl/tick_pwm_shadow.sv
module tick_pwm_shadow
    import tick_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  pwm_cfg_t cfg_in,
    output pwm_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_in;
    end

    // R7: values are held between loads
    a_r7_hold_between_wraps: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q));

    // R7: a load captures the presented values
    a_r7_take_on_load: assert property (@(posedge clk) disable iff (rst)
        load |=> (cfg_q == $past(cfg_in)));

endmodule

// File: rtl/tick_pwm_counter.sv
module tick_pwm_counter
    import tick_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    input  cnt_t span,
    output cnt_t cnt,
    output logic running,
    output logic wrap
);

    localparam cnt_t STEP_ONE = cnt_t'(1);

    cnt_act_e act;

    always_comb begin
        act  = pick_act(en, tick, cnt == span);
        wrap = (act == ACT_WRAP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else begin
            running <= en;
            unique case (act)
                ACT_CLEAR: cnt <= '0;
                ACT_HOLD:  cnt <= cnt;
                ACT_STEP:  cnt <= cnt + STEP_ONE;
                ACT_WRAP:  cnt <= '0;
                default:   cnt <= '0;
            endcase
        end
    end

    // R2: count never leaves the active span
    a_r2_cnt_within_span: assert property (@(posedge clk) disable iff (rst)
        cnt <= span);

    // R2: the end strobe returns the count to zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (en && tick && (cnt == span)) |=> (cnt == '0));

    // R3: no strobe, no movement
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(cnt));

    // R8: disabled means cleared and idle
    a_r8_clear_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> ((cnt == '0) && !running));

endmodule

// File: rtl/tick_pwm_level.sv
module tick_pwm_level
    import tick_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     running,
    input  cnt_t     cnt,
    input  pwm_cfg_t cfg,
    output logic     pwm_o
);

    always_comb pwm_o = level_f(running, cnt, cfg.duty);

    // R8: idle output is low
    a_r8_low_when_idle: assert property (@(posedge clk) disable iff (rst)
        !running |-> !pwm_o);

    // R5: duty above span keeps the output high
    a_r5_full_duty: assert property (@(posedge clk) disable iff (rst)
        (running && (cfg.duty > cfg.span)) |-> pwm_o);

    // R6: zero duty keeps the output low
    a_r6_zero_duty: assert property (@(posedge clk) disable iff (rst)
        (cfg.duty == '0) |-> !pwm_o);

endmodule

// File: rtl/tick_pwm.sv
module tick_pwm
    import tick_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [PWM_W-1:0] duty_i,
    input  logic [PWM_W-1:0] span_i,
    output logic             pwm_o
);

    pwm_cfg_t cfg_in;
    pwm_cfg_t cfg_q;
    cnt_t     cnt;
    logic     running;
    logic     wrap;
    logic     load;

    always_comb begin
        cfg_in.duty = duty_i;
        cfg_in.span = span_i;
        load        = !en || wrap;
    end

    tick_pwm_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    tick_pwm_counter u_counter (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .tick    (tick),
        .span    (cfg_q.span),
        .cnt     (cnt),
        .running (running),
        .wrap    (wrap)
    );

    tick_pwm_level u_level (
        .clk     (clk),
        .rst     (rst),
        .running (running),
        .cnt     (cnt),
        .cfg     (cfg_q),
        .pwm_o   (pwm_o)
    );

    // R1: output low in the cycle after reset
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !pwm_o);

endmodule

// File: tb/tick_pwm_tb.sv
module tick_pwm_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] duty_i = '0;
    logic [7:0] span_i = '0;
    logic       pwm_o;

    int unsigned n_total = 0;
    int unsigned n_pass  = 0;
    bit          done    = 1'b0;

    always #2 clk = ~clk;

    tick_pwm u_dut (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .tick   (tick),
        .duty_i (duty_i),
        .span_i (span_i),
        .pwm_o  (pwm_o)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        n_total++;
        if (got !== exp)
            $display("FAIL %s: pwm_o=%b expected %b", req, got, exp);
        else
            n_pass++;
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic setup(input logic [7:0] d, input logic [7:0] s);
        @(negedge clk);
        en = 1'b0;
        duty_i = d;
        span_i = s;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
    endtask

    // checks n strobes of the pattern starting at position k0 in the cycle
    task automatic run_check(input int d, input int s, input int n, input int k0,
                             input int gap, input string req);
        for (int k = 0; k < n; k++) begin
            logic exp;
            exp = (((k0 + k) % (s + 1)) < d);
            chk(pwm_o, exp, req);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                chk(pwm_o, exp, "R3 no strobe no change");
            end
            pulse_tick();
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        en  = 1'b1;
        repeat (3) @(negedge clk);
        chk(pwm_o, 1'b0, "R1 low in reset");
        rst = 1'b0;
        en  = 1'b0;
        @(negedge clk);
        chk(pwm_o, 1'b0, "R1 low after reset");
        setup(8'd1, 8'd3);
        run_check(1, 3, 4, 0, 0, "R1 first cycle from zero");
    endtask

    task automatic t_basic();
        setup(8'd3, 8'd7);
        run_check(3, 7, 16, 0, 2, "R4 R2 duty 3 span 7");
        setup(8'd6, 8'd9);
        run_check(6, 9, 20, 0, 0, "R4 R2 duty 6 span 9");
    endtask

    task automatic t_full();
        setup(8'hFF, 8'hFE);
        run_check(256, 254, 260, 0, 0, "R5 full duty");
        setup(8'd9, 8'd4);
        run_check(9, 4, 10, 0, 0, "R5 duty above span");
    endtask

    task automatic t_zero();
        setup(8'd0, 8'd5);
        run_check(0, 5, 12, 0, 1, "R6 zero duty");
    endtask

    task automatic t_span0();
        setup(8'd1, 8'd0);
        run_check(1, 0, 6, 0, 1, "R9 span zero");
    endtask

    task automatic t_midchange();
        setup(8'd2, 8'd5);
        run_check(2, 5, 2, 0, 0, "R7 old values start");
        @(negedge clk);
        duty_i = 8'd1;
        span_i = 8'd3;
        run_check(2, 5, 4, 2, 0, "R7 old cycle finishes");
        run_check(1, 3, 8, 0, 0, "R7 new values after wrap");
    endtask

    task automatic t_disable();
        setup(8'd3, 8'd6);
        run_check(3, 6, 4, 0, 0, "R8 before disable");
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        chk(pwm_o, 1'b0, "R8 low when disabled");
        pulse_tick();
        chk(pwm_o, 1'b0, "R8 strobe ignored while off");
        pulse_tick();
        chk(pwm_o, 1'b0, "R8 strobe ignored while off");
        en = 1'b1;
        @(negedge clk);
        run_check(3, 6, 7, 0, 0, "R8 restart at zero");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_full();
        t_zero();
        t_span0();
        t_midchange();
        t_disable();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

endmodule